// File: doc/BRIEF.md
# Overwriting Inbound Mailbox Queue

This block is a small inbound word queue placed between an external producer and a consumer. The producer pushes 32-bit words and the consumer pops them oldest first. A push is never refused. When the queue already holds four words, the newest word is replaced and the occupancy stays at four. Every pop returns the occupancy it found. A pop that finds the queue empty fails and arms a waiting flag. The next push clears that flag and gives the consumer a one-cycle notify pulse.

The consumer can peek at the occupancy and the stored slots at any time without changing them. A load port replaces the whole state in one cycle, for example to restore a saved context, and a clear port empties the queue. Clear has priority over load, and load has priority over push and pop.

Top module: `mbox_overwrite_q`

## Requirements
- R1: After reset, `count`, `waiting`, `notify` and `popValid` are 0 and `peekSlots` reads all zero.
- R2: A push that meets an occupancy below 3 stores the word in slot index equal to that occupancy and increments `count`. Words are popped in push order.
- R3: A push that meets an occupancy of 3 or 4 leaves `count` at 4 and writes only slot 3 (bits 127:96 of `peekSlots`), so in a full queue the newest word is overwritten.
- R4: A pop on a non-empty queue returns slot 0 on `popData`, with the pre-pop occupancy on `popCount` and `popValid` high, one cycle after `popReq`. The remaining words move one slot toward slot 0 and `count` decrements.
- R5: A pop on an empty queue returns `popCount` = 0 with `popValid` high one cycle later, leaves `count` at 0 and sets `waiting`. `waiting` is only ever high while `count` is 0.
- R6: A push accepted while `waiting` is high clears `waiting` and raises `notify` for exactly one cycle, in the cycle after the push.
- R7: When `pushValid` and `popReq` are high in the same cycle, the pop is applied first and the push after it.
- R8: `peekSlots` shows slot i at bits [32*i+31:32*i] while `count` is non-zero, and all zero while empty. Reading it changes nothing.
- R9: `loadReq` sets `count` to `loadCount`, clamped to 4. It sets all four slots from `loadData` (slot i at bits [32*i+31:32*i]) and clears `waiting`. Push and pop are ignored in that cycle.
- R10: `clearReq` sets `count` to 0 and all slots to zero and clears `waiting`. It overrides load, push and pop in that cycle and produces no pop result.
- R11: `count` is 3 bits wide and never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pushValid | input | 1 | Push `pushData` this cycle |
| pushData | input | 32 | Word to push |
| popReq | input | 1 | Pop request |
| clearReq | input | 1 | Empty the queue |
| loadReq | input | 1 | Load the whole state |
| loadCount | input | 3 | Occupancy to load (clamped to 4) |
| loadData | input | 128 | Slot values to load, slot i at bits 32*i+31:32*i |
| count | output | 3 | Current occupancy |
| waiting | output | 1 | Consumer popped an empty queue and waits |
| notify | output | 1 | One-cycle pulse after a push ended a wait |
| popValid | output | 1 | Pop result valid |
| popData | output | 32 | Popped word (zero on failure) |
| popCount | output | 3 | Occupancy seen by the pop |
| peekSlots | output | 128 | Current slots, zero while empty |

## Verification
State updates from push, pop, load and clear appear on `count`, `waiting` and `peekSlots` one clock edge after the request. The bench drives each request at a falling edge and reads these outputs at the next falling edge. The pop result and the `notify` pulse are registered and are also due one edge after the request. A monitor samples them 2 ns after each rising edge and matches every `popValid` against a queue of expected results, which the driver fills when it issues the pop. A leftover expected entry at the end of the run counts as a failure. A `notify` that stays high for a second cycle is also a failure.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int SEL_W = 8;

  typedef struct packed {
    logic             clear;
    logic             load;
    logic             shift;
    logic             wrEn;
    logic [SEL_W-1:0] wrIdx;
    logic             wrLast;
  } dpCtl_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             popReq,
  input  logic             clearReq,
  input  logic             loadReq,
  input  logic [CNT_W-1:0] loadCount,
  output dpCtl_t           ctl,
  output logic [CNT_W-1:0] count,
  output logic             waiting,
  output logic             notify,
  output logic             popValid,
  output logic [CNT_W-1:0] popCount
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);

  logic [CNT_W-1:0] cntAfterPop, cntNext;
  logic             waitAfterPop, waitNext, notifyNext;
  logic             popHit, popMiss, normalOp;

  always_comb begin
    normalOp     = !clearReq && !loadReq;
    popHit       = normalOp && popReq && (count != '0);
    popMiss      = normalOp && popReq && (count == '0);
    cntAfterPop  = popHit ? count - CNT_W'(1) : count;
    waitAfterPop = popHit ? 1'b0 : (popMiss ? 1'b1 : waiting);

    ctl          = '0;
    ctl.shift    = popHit;
    cntNext      = cntAfterPop;
    waitNext     = waitAfterPop;
    notifyNext   = 1'b0;

    if (clearReq) begin
      ctl.clear = 1'b1;
      cntNext   = '0;
      waitNext  = 1'b0;
    end else if (loadReq) begin
      ctl.load = 1'b1;
      cntNext  = (loadCount > FULL) ? FULL : loadCount;
      waitNext = 1'b0;
    end else if (pushValid) begin
      ctl.wrLast = 1'b1;
      if (cntAfterPop < LAST) begin
        ctl.wrEn  = 1'b1;
        ctl.wrIdx = SEL_W'(cntAfterPop);
        cntNext   = cntAfterPop + CNT_W'(1);
      end else begin
        cntNext = FULL;
      end
      notifyNext = waitAfterPop;
      waitNext   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      waiting  <= 1'b0;
      notify   <= 1'b0;
      popValid <= 1'b0;
      popCount <= '0;
    end else begin
      count    <= cntNext;
      waiting  <= waitNext;
      notify   <= notifyNext;
      popValid <= popHit || popMiss;
      popCount <= (popHit || popMiss) ? count : '0;
    end
  end
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  input  logic [DATA_W-1:0]       pushData,
  input  logic [DEPTH*DATA_W-1:0] loadData,
  output logic [DATA_W-1:0]       popData,
  output logic [DEPTH*DATA_W-1:0] slotsFlat
);
  logic [DATA_W-1:0] slotQ [DEPTH];
  logic [DATA_W-1:0] slotD [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) slotD[i] = slotQ[i];
    if (ctl.clear) begin
      for (int i = 0; i < DEPTH; i++) slotD[i] = '0;
    end else if (ctl.load) begin
      for (int i = 0; i < DEPTH; i++) slotD[i] = loadData[i*DATA_W +: DATA_W];
    end else begin
      if (ctl.shift)
        for (int i = 0; i < DEPTH - 1; i++) slotD[i] = slotQ[i+1];
      for (int i = 0; i < DEPTH - 1; i++)
        if (ctl.wrEn && ctl.wrIdx == SEL_W'(i)) slotD[i] = pushData;
      if (ctl.wrLast) slotD[DEPTH-1] = pushData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) slotQ[i] <= '0;
      popData <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) slotQ[i] <= slotD[i];
      popData <= ctl.shift ? slotQ[0] : '0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign slotsFlat[g*DATA_W +: DATA_W] = slotQ[g];
  end
endmodule

// File: rtl/mbox_overwrite_q.sv
module mbox_overwrite_q
  import mbox_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pushValid,
  input  logic [DATA_W-1:0]       pushData,
  input  logic                    popReq,
  input  logic                    clearReq,
  input  logic                    loadReq,
  input  logic [CNT_W-1:0]        loadCount,
  input  logic [DEPTH*DATA_W-1:0] loadData,
  output logic [CNT_W-1:0]        count,
  output logic                    waiting,
  output logic                    notify,
  output logic                    popValid,
  output logic [DATA_W-1:0]       popData,
  output logic [CNT_W-1:0]        popCount,
  output logic [DEPTH*DATA_W-1:0] peekSlots
);
  dpCtl_t                  ctl;
  logic [DEPTH*DATA_W-1:0] slotsFlat;

  mbox_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .popReq(popReq),
    .clearReq(clearReq), .loadReq(loadReq), .loadCount(loadCount),
    .ctl(ctl), .count(count), .waiting(waiting), .notify(notify),
    .popValid(popValid), .popCount(popCount)
  );

  mbox_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pushData(pushData),
    .loadData(loadData), .popData(popData), .slotsFlat(slotsFlat)
  );

  assign peekSlots = (count == '0) ? '0 : slotsFlat;
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             pushValid,
  input logic             popReq,
  input logic             clearReq,
  input logic             loadReq,
  input logic [CNT_W-1:0] count,
  input logic             waiting,
  input logic             notify,
  input logic             popValid,
  input logic [CNT_W-1:0] popCount
);
  // R11: occupancy bound
  p_count_max_r11: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R3: full queue stays full on a plain push
  p_full_push_r3: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(DEPTH) && pushValid && !popReq && !clearReq && !loadReq)
      |=> count == CNT_W'(DEPTH));

  // R4: every admitted pop yields a result next cycle
  p_pop_result_r4: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !clearReq && !loadReq) |=> popValid);

  // R5: failed pop arms waiting and reports zero
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && popReq && !pushValid && !clearReq && !loadReq)
      |=> (waiting && popValid && popCount == '0));

  // R5: waiting only while empty
  p_wait_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    waiting |-> count == '0);

  // R6: notify only follows an admitted push that met a waiting consumer
  p_notify_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(notify) |-> $past(pushValid && !clearReq && !loadReq));

  // R10: clear empties the queue
  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (count == '0 && !waiting && !popValid));
endmodule

bind mbox_overwrite_q mbox_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .popReq(popReq),
  .clearReq(clearReq), .loadReq(loadReq), .count(count), .waiting(waiting),
  .notify(notify), .popValid(popValid), .popCount(popCount)
);

// File: tb/mbox_overwrite_q_tb.sv
`timescale 1ns/1ps
module mbox_overwrite_q_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         pushValid = 1'b0, popReq = 1'b0, clearReq = 1'b0, loadReq = 1'b0;
  logic [31:0]  pushData = '0;
  logic [2:0]   loadCount = '0;
  logic [127:0] loadData = '0;
  logic [2:0]   count, popCount;
  logic         waiting, notify, popValid;
  logic [31:0]  popData;
  logic [127:0] peekSlots;

  int tests = 0, fails = 0;
  logic [31:0] model[$];
  logic        mWait = 1'b0;
  logic        expNotify = 1'b0;
  logic [31:0] expData[$];
  logic [2:0]  expCnt[$];
  string       expTag[$];

  always #4 clk = ~clk;

  mbox_overwrite_q u_dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .popReq(popReq), .clearReq(clearReq), .loadReq(loadReq),
    .loadCount(loadCount), .loadData(loadData), .count(count),
    .waiting(waiting), .notify(notify), .popValid(popValid),
    .popData(popData), .popCount(popCount), .peekSlots(peekSlots)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for pop results and notify pulses
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      if (popValid) begin
        if (expData.size() == 0) begin
          check(1'b0, "R4 unexpected pop result", popCount, 0);
        end else begin
          automatic logic [31:0] d = expData.pop_front();
          automatic logic [2:0]  c = expCnt.pop_front();
          automatic string       t = expTag.pop_front();
          check(popData == d, {t, " popData"}, popData, d);
          check(popCount == c, {t, " popCount"}, popCount, c);
        end
      end
      check(notify == expNotify, "R6 notify", notify, expNotify);
    end
  end

  // one drive cycle: inputs set at a falling edge, results read at the next
  task automatic step(input bit psh, input logic [31:0] d, input bit pp,
                      input bit clr, input bit ld, input logic [2:0] lc,
                      input logic [127:0] ldd, input string tag);
    pushValid = psh; pushData = d; popReq = pp;
    clearReq = clr; loadReq = ld; loadCount = lc; loadData = ldd;
    expNotify = 1'b0;
    if (clr) begin
      model = {}; mWait = 1'b0;
    end else if (ld) begin
      model = {};
      for (int i = 0; i < ((lc > 4) ? 4 : int'(lc)); i++) model.push_back(ldd[i*32 +: 32]);
      mWait = 1'b0;
    end else begin
      if (pp) begin
        expTag.push_back(tag);
        expCnt.push_back(3'(model.size()));
        if (model.size() > 0) begin
          expData.push_back(model.pop_front()); mWait = 1'b0;
        end else begin
          expData.push_back('0); mWait = 1'b1;
        end
      end
      if (psh) begin
        if (model.size() < 4) model.push_back(d);
        else model[3] = d;
        expNotify = mWait;
        mWait = 1'b0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    pushValid = 1'b0; popReq = 1'b0; clearReq = 1'b0; loadReq = 1'b0;
    check(count == 3'(model.size()), {tag, " count"}, count, model.size());
    check(waiting == mWait, {tag, " waiting"}, waiting, mWait);
    if (model.size() == 0)
      check(peekSlots == '0, {"R8 peek empty ", tag}, peekSlots, 0);
    else
      for (int i = 0; i < model.size(); i++)
        check(peekSlots[i*32 +: 32] == model[i], {"R8 peek ", tag},
              peekSlots[i*32 +: 32], model[i]);
  endtask

  task automatic push(input logic [31:0] d, input string tag);
    step(1, d, 0, 0, 0, 0, '0, tag);
  endtask
  task automatic pop(input string tag);
    step(0, '0, 1, 0, 0, 0, '0, tag);
  endtask
  task automatic idle(input string tag);
    step(0, '0, 0, 0, 0, 0, '0, tag);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(count == 0 && !waiting && !notify && !popValid && peekSlots == '0,
          "R1 reset", {count, waiting, notify, popValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R2 fill below three
    push(32'hA1, "R2 push1");
    push(32'hB2, "R2 push2");
    push(32'hC3, "R2 push3");
    // R3 saturation and overwrite of the newest
    push(32'hD4, "R3 push4");
    check(peekSlots[127:96] == 32'hD4, "R3 slot3", peekSlots[127:96], 32'hD4);
    push(32'hE5, "R3 overwrite");
    check(peekSlots[127:96] == 32'hE5, "R3 slot3 newest", peekSlots[127:96], 32'hE5);
    idle("R8 peek stable");
    // R4 drain in order with pre-pop counts
    pop("R4 pop4");
    pop("R4 pop3");
    pop("R4 pop2");
    pop("R4 pop1");
    // R5 pop on empty
    pop("R5 empty pop");
    idle("R5 still waiting");
    // R6 push ends wait
    push(32'h1234_5678, "R6 wake push");
    idle("R6 notify ends");
    // R7 push and pop together, non-empty then empty
    step(1, 32'h77, 1, 0, 0, 0, '0, "R7 pop then push");
    pop("R7 drain");
    step(1, 32'h88, 1, 0, 0, 0, '0, "R7 empty pop then push");
    idle("R7 notify ends");
    // R7 full queue: pop frees a slot so the push does not overwrite
    push(32'h90, "R7 fill"); push(32'h91, "R7 fill"); push(32'h92, "R7 fill");
    step(1, 32'h93, 1, 0, 0, 0, '0, "R7 full pop push");
    // R9 load, clamped load, with push ignored
    pop("R5 arm wait"); pop("R5 arm wait"); pop("R5 arm wait");
    pop("R5 arm wait"); pop("R5 arm wait");
    step(1, 32'hFF, 1, 0, 1, 3'd3, {32'h4, 32'h3, 32'h2, 32'h1}, "R9 load3");
    pop("R9 pop loaded");
    step(0, '0, 0, 0, 1, 3'd7, {32'h44, 32'h33, 32'h22, 32'h11}, "R9 load clamp");
    // R10 clear overrides everything
    step(1, 32'hAB, 1, 1, 1, 3'd2, {4{32'h5}}, "R10 clear");
    pop("R10 pop after clear");
    idle("R10 idle");
    check(expData.size() == 0, "R4 outstanding results", expData.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule